// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a cycle-accurate model of the front end of a synchronous pipelined static RAM. Each rising clock edge samples the address, the write data and the control pins. These are three chip enables, two address-status strobes, an advance input, a global write, a byte-write enable and four per-lane write enables. From them the block decides whether the edge starts a burst, continues it, suspends it, deselects the device or does nothing. Writes commit into an internal array on that same edge. Reads pass through an output register and appear one clock later.

Either strobe can open a burst. The processor-side strobe always opens a read and is masked while the primary enable is inactive. The controller-side strobe opens a read or a write according to the write inputs. Once a burst is open, the advance input steps a two-bit counter. A mode input chooses between a wrapping linear order and an XOR (interleaved) order. A burst can then continue even with the primary enable inactive.

An asynchronous output-enable input disables the data outputs. A sleep input stops all accesses while it is high and for two edges after it falls. The array contents are kept through sleep.

Top module: `pbsram_ctrl`

## Requirements
- R1: An edge that samples `ce_n` high and `adsc_n` low deselects the device. It ends any open burst. A read issued on the previous edge never reaches the outputs. `dq_en` is low after this edge. With `ce_n` high, `adsp_n` is ignored.
- R2: An edge that samples either strobe active, `ce_n` low and a secondary enable inactive (`ce2` low or `ce2_n` high) deselects the device. It has the effects listed in R1 and writes nothing. `ce2` and `ce2_n` have no effect on continue or suspend edges.
- R3: A burst opened by `adsp_n` low (with `ce_n` low) is a read at `addr`, whatever the write inputs are.
- R4: A burst opened by `adsc_n` low while `adsp_n` is high is a write at `addr` when the write mask of R5 is non-zero. Otherwise it is a read at `addr`.
- R5: `gw_n` low writes all four lanes. With `gw_n` high and `bwe_n` low, `bw_n[i]` low writes lane i, which is `din[i*LW +: LW]`. When both `gw_n` and `bwe_n` are high, or `bw_n` is all ones, the cycle is a read.
- R6: On an edge with no strobe active and a burst open, `adv_n` low advances the burst count and `adv_n` high holds it. The access address keeps the burst base's upper bits. Its low two bits are (base + count) mod 4 when `seq_lin` is 1, and base XOR count when `seq_lin` is 0. The access is a write or a read as in R5.
- R7: Data read on edge n is on `dout` with `dq_en` high after edge n+1, provided edge n+1 neither deselects the device nor falls in sleep.
- R8: `oe_n` high holds `dq_en` low at once, and `dout` is zero whenever `dq_en` is low.
- R9: Edges that sample `sleep` high, and the two edges after the last such edge, ignore all commands. They close the burst, drop pipelined read data and leave the array unchanged.
- R10: After a processor-strobe read start, a following edge with `adv_n` high and the write inputs active writes to the burst's current address.
- R11: After reset, `dq_en` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every pin except `oe_n` is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | AW | Word address |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| seq_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Sleep request, active high |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not driven |
| dq_en | output | 1 | Output drive enable (low means high-impedance) |

## Verification
The bench builds the block with AW=6 and DW=32, which gives a 64-word array with 8-bit lanes. With that size it can fill every word, then run a four-beat burst plus a suspend from every start address in both burst orders, which covers all wrap positions. All sixteen lane masks can be tried on one word against an arithmetic reference. Separate sequences check deselects through each enable, sleep entry and the two-edge wake delay, output-enable gating, and the write that follows a processor-strobe start.

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          ce2,
  input  logic          ce2_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [3:0]    bw_n,
  input  logic          oe_n,
  input  logic          seq_lin,
  input  logic          sleep,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dq_en
);
  localparam int LW    = DW / 4;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    slp_q;
  logic          active;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic          rd_pend;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] out_q;
  logic          out_vld;

  wire hold_off = sleep | (|slp_q);
  wire ads_p    = ~adsp_n & ~ce_n;
  wire ads      = ads_p | ~adsc_n;
  wire sel_ok   = ~ce_n & ce2 & ~ce2_n;
  wire desel    = ads & ~sel_ok;
  wire start    = ~hold_off & ads & sel_ok;
  wire cont     = ~hold_off & ~ads & active;

  wire [1:0]    cnt_nx = start ? 2'd0 : (adv_n ? cnt : cnt + 2'd1);
  wire [AW-1:0] bbase  = start ? addr : base;
  wire [1:0]    lo     = seq_lin ? (bbase[1:0] + cnt_nx) : (bbase[1:0] ^ cnt_nx);
  wire [AW-1:0] acc    = {bbase[AW-1:2], lo};

  wire [3:0] wmask = ~gw_n ? 4'hF : (~bwe_n ? ~bw_n : 4'h0);
  wire       do_wr = (cont | (start & ~ads_p)) & (|wmask);
  wire       do_rd = (start | cont) & ~do_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q   <= '0;
      active  <= 1'b0;
      base    <= '0;
      cnt     <= '0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      out_vld <= 1'b0;
    end else begin
      slp_q   <= {slp_q[0], sleep};
      if (hold_off)  active <= 1'b0;
      else if (ads)  active <= sel_ok;
      if (start | cont) begin
        base <= bbase;
        cnt  <= cnt_nx;
      end
      rd_pend <= do_rd;
      rd_addr <= acc;
      out_vld <= rd_pend & ~hold_off & ~desel;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr)
      for (int i = 0; i < 4; i++)
        if (wmask[i]) mem[acc][i*LW +: LW] <= din[i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rd_pend) out_q <= mem[rd_addr];
  end

  assign dq_en = out_vld & ~oe_n;
  assign dout  = dq_en ? out_q : '0;
endmodule

// File: rtl/pbsram_ctrl_chk.sv
module pbsram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic ce2,
  input logic ce2_n,
  input logic adsp_n,
  input logic adsc_n,
  input logic oe_n,
  input logic sleep,
  input logic dq_en
);
  p_desel_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !adsc_n) |=> !dq_en);

  p_desel_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && (!ce2 || ce2_n) && (!adsp_n || !adsc_n)) |=> !dq_en);

  p_oe_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_en);

  p_sleep_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !dq_en);
endmodule

bind pbsram_ctrl pbsram_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .oe_n(oe_n), .sleep(sleep), .dq_en(dq_en)
);

// File: tb/sim_pbsram_ctrl.sv
module sim_pbsram_ctrl;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic ce_n, ce2, ce2_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, seq_lin, sleep;
  logic [3:0] bw_n;
  logic [DW-1:0] din, dout;
  logic dq_en;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] mref [int];
  bit          pv = 0;
  logic [31:0] pd = '0;
  string       ptag = "R7";

  always #5 clk = ~clk;

  pbsram_ctrl #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .seq_lin(seq_lin), .sleep(sleep), .din(din),
    .dout(dout), .dq_en(dq_en)
  );

  function automatic int bseq(int a, int k, bit lin);
    int lo = lin ? ((a + k) & 3) : ((a & 3) ^ k);
    return (a & ~3) | lo;
  endfunction

  function automatic logic [31:0] pat(int a);
    return (a + 1) * 32'h9E3779B9;
  endfunction

  task automatic dflt();
    addr = '0; ce_n = 0; ce2 = 1; ce2_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; sleep = 0; din = '0;
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit ev, logic [31:0] ed, string tag);
    bit en_exp;
    string t;
    @(posedge clk);
    @(negedge clk);
    en_exp = pv & ~oe_n;
    t = oe_n ? "R8" : ptag;
    check(dq_en == en_exp, {t, " dq_en"}, {31'd0, dq_en}, {31'd0, en_exp});
    check(dout == (en_exp ? pd : 32'd0), {t, " dout"}, dout, en_exp ? pd : 32'd0);
    pv = ev; pd = ed; ptag = tag;
    dflt();
  endtask

  task automatic adsc_read(int a, string tag);
    adsc_n = 0; addr = a[AW-1:0];
    step(1, mref[a], tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    dflt();
    seq_lin = 0;
    repeat (3) @(negedge clk);
    check(dq_en == 1'b0 && dout == '0, "R11 reset", {31'd0, dq_en}, 32'd0);
    rst_n = 1;

    // R4/R5: fill every word through controller-strobe writes
    for (int a = 0; a < 64; a++) begin
      adsc_n = 0; addr = a[AW-1:0]; din = pat(a);
      if (a % 2 == 0) gw_n = 0; else begin bwe_n = 0; bw_n = 4'h0; end
      step(0, '0, "R4");
      mref[a] = pat(a);
    end

    // R3/R6/R7: bursts from every start in both orders
    for (int lin = 0; lin < 2; lin++) begin
      for (int a = 0; a < 64; a++) begin
        seq_lin = lin[0];
        adsp_n = 0; addr = a[AW-1:0];
        if (a % 2 == 1) begin gw_n = 0; din = ~mref[a]; end
        step(1, mref[a], "R3");
        for (int k = 1; k < 4; k++) begin
          adv_n = 0; ce_n = 1; ce2 = 0;
          step(1, mref[bseq(a, k, lin[0])], "R6");
        end
        step(1, mref[bseq(a, 3, lin[0])], "R6 suspend");
      end
    end

    // R5: every lane mask on one word
    seq_lin = 0;
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d = 32'h11223344 * (m + 3);
      adsc_n = 0; addr = 5; bwe_n = 0; bw_n = ~m[3:0]; din = d;
      if (m == 0) step(1, mref[5], "R5 empty mask reads");
      else step(0, '0, "R5");
      for (int i = 0; i < 4; i++) if (m[i]) mref[5][i*8 +: 8] = d[i*8 +: 8];
      adsc_read(5, "R5");
    end
    adsc_n = 0; addr = 6; gw_n = 0; bwe_n = 0; bw_n = 4'hE; din = 32'hCAFEF00D;
    step(0, '0, "R5");
    mref[6] = 32'hCAFEF00D;
    adsc_read(6, "R5 global override");

    // R10: write after processor-strobe start
    adsp_n = 0; addr = 9; step(1, mref[9], "R10");
    gw_n = 0; din = 32'h0BADBEEF; step(0, '0, "R10");
    mref[9] = 32'h0BADBEEF;
    adsc_read(9, "R10");

    // R1: deselect drops pending read, ends burst; masked processor strobe
    adsp_n = 0; addr = 3; step(1, mref[3], "R1");
    pv = 0; ce_n = 1; adsc_n = 0; step(0, '0, "R1");
    adv_n = 0; step(0, '0, "R1");
    seq_lin = 1;
    adsp_n = 0; addr = 16; step(1, mref[16], "R1");
    seq_lin = 1; ce_n = 1; adsp_n = 0; adv_n = 0; addr = 40; step(1, mref[17], "R1");

    // R2: secondary enables
    adsp_n = 0; addr = 20; step(1, mref[20], "R2");
    pv = 0; ce2 = 0; adsp_n = 0; addr = 22; step(0, '0, "R2");
    adv_n = 0; step(0, '0, "R2");
    adsp_n = 0; addr = 21; step(1, mref[21], "R2");
    pv = 0; ce2_n = 1; adsc_n = 0; addr = 21; gw_n = 0; din = 32'h12345678; step(0, '0, "R2");
    adsc_read(21, "R2");
    seq_lin = 0;
    adsp_n = 0; addr = 24; step(1, mref[24], "R2");
    seq_lin = 0; ce2 = 0; ce2_n = 1; adv_n = 0; step(1, mref[25], "R2");

    // R8: output enable gating
    adsc_read(30, "R8");
    oe_n = 1; adsc_n = 0; addr = 31; step(1, mref[31], "R8");
    adsc_read(32, "R8");
    adsc_read(33, "R8");

    // R9: sleep
    adsc_read(40, "R9");
    pv = 0; sleep = 1; adsc_n = 0; addr = 2; gw_n = 0; din = 32'hDEAD0001; step(0, '0, "R9");
    sleep = 1; adsc_n = 0; addr = 2; gw_n = 0; din = 32'hDEAD0002; step(0, '0, "R9");
    adsc_n = 0; addr = 2; gw_n = 0; din = 32'hDEAD0003; step(0, '0, "R9");
    adsc_n = 0; addr = 2; gw_n = 0; din = 32'hDEAD0004; step(0, '0, "R9");
    adv_n = 0; step(0, '0, "R9");
    adsc_read(2, "R9");
    adsc_read(7, "R9");

    pv = 0; ce_n = 1; adsc_n = 0; step(0, '0, "R1");
    step(0, '0, "R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule